// File: doc/BRIEF.md
# Amplifier Channel Power-Gain Sequencer

This block is the digital sequencer that powers the channels of a stereo switching audio amplifier up and down without audible pops. Each channel has an active-low standby request and a two-bit gain preset. The block produces a gain step code for the analog gain stage, an output-drive enable (low means the output bridge is in high impedance) and a channel-active status. A shared over-temperature flag and a per-channel short-circuit flag arrive as digital inputs from the protection circuits.

When standby is released, the channel enables its outputs at mute. It holds them at mute for a fixed number of clock cycles. It then climbs one gain level per dwell period until it reaches the selected preset. When standby is requested, it descends one level per dwell period to mute and only then releases the output drive. A short circuit shuts the channel off at once and holds it off until standby has been asserted and released again. An over-temperature condition also shuts the channel off at once, but the channel wakes by itself when the flag clears. The channels are independent, and an all-off status reports when none of them is driving.

Top module: `amp_gain_seq_pair`

## Requirements
- R1: After reset every channel has gain step 0 (mute), output drive off and active status low, and the all-off status is high.
- R2: While standby is low the channel stays off. After standby goes high, the output drive turns on one cycle later at gain step 0, and the gain stays at mute for MUTE_CYC cycles.
- R3: The gain step code is 0 for mute and 1, 2, 3, 4 for 6, 12, 18 and 24 dB. The gain select value s (bit 1 high, bit 0 low) settles at step s+1: 00 gives 1, 01 gives 2, 10 gives 3 and 11 gives 4.
- R4: After the mute delay the gain rises by one step every DWELL_CYC cycles, and stops at the selected step.
- R5: A change of gain select while running moves the gain one step per DWELL_CYC cycles toward the new step, in either direction.
- R6: After standby goes low the gain falls one step per DWELL_CYC cycles to 0. The output drive turns off on the cycle after mute is reached, and never while the gain is above 0.
- R7: If standby goes low during the upward ramp, the gain takes no further upward step and falls from the step it had reached.
- R8: A short-circuit flag while the output drive is on turns the drive off and sets the gain to 0 on the next cycle. The channel stays off while standby stays high, even after the flag clears. A low-then-high standby cycle restarts the wake-up. A short-circuit flag while the channel is off has no effect.
- R9: The over-temperature flag turns the drive of every channel off on the next cycle. When it clears, channels whose standby is high restart the wake-up with no standby toggle.
- R10: The channels run independently, and the all-off status is high exactly when no channel has its output drive on.
- R11: The active status is high only from the end of the mute delay until standby is requested or a fault occurs. It is low during mute and during the downward ramp.
- R12: While the drive is on, the gain changes by at most one step per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_n | input | NCH | Per-channel standby request, low = standby |
| gsel | input | 2*NCH | Per-channel gain select, 2 bits per channel |
| short_flt | input | NCH | Per-channel short-circuit flag |
| hot_flt | input | 1 | Shared over-temperature flag |
| gain_step | output | 3*NCH | Per-channel gain step, 0 = mute, 1..4 = 6..24 dB |
| out_en | output | NCH | Per-channel output drive enable, low = high impedance |
| ch_active | output | NCH | Per-channel active status |
| all_off | output | 1 | High when no channel drives its output |

## Verification
The hardest situation to reach from the ports is a standby request that arrives in the middle of the upward ramp, just after a step. The reversal must be told apart from the next upward step that was due. The stimulus counts cycles from the standby release through the mute delay and two dwell periods, then drops standby on the cycle the second step appears. It checks that the step which would have come one dwell later is a downward one. The short-circuit latch is reached in a similar way: the flag is pulsed and cleared with standby still high, so that only the latch keeps the channel off.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

  typedef enum logic [1:0] {
    CH_OFF  = 2'd0,
    CH_MUTE = 2'd1,
    CH_RUN  = 2'd2,
    CH_DOWN = 2'd3
  } ch_state_t;

  localparam int GAIN_W = 3;
  localparam int SEL_W  = 2;

  // gain select value s maps to gain step s+1 (step 0 is mute)
  function automatic logic [GAIN_W-1:0] sel_to_step(input logic [SEL_W-1:0] s);
    return GAIN_W'(s) + GAIN_W'(1);
  endfunction

endpackage

// File: rtl/amp_dwell_timer.sv
module amp_dwell_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick   = run && (cnt_q == limit - CNT_W'(1));
  assign cnt_en = clr || run;

  always_comb begin
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/amp_chan_seq.sv
module amp_chan_seq
  import amp_seq_pkg::*;
#(
  parameter int MUTE_CYC  = 4000,
  parameter int DWELL_CYC = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby_n,
  input  logic [SEL_W-1:0]  gsel,
  input  logic              short_flt,
  input  logic              hot_flt,
  output logic [GAIN_W-1:0] gain_step,
  output logic              out_en,
  output logic              ch_active
);

  localparam int MAX_CYC = (MUTE_CYC > DWELL_CYC) ? MUTE_CYC : DWELL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] MUTE_LIM  = CNT_W'(MUTE_CYC);
  localparam logic [CNT_W-1:0] DWELL_LIM = CNT_W'(DWELL_CYC);

  ch_state_t         st_q, st_d;
  logic [GAIN_W-1:0] gain_q, gain_d, target;
  logic              lat_q, lat_d;
  logic              wake_ok, fault, t_clr, t_run, tick;
  logic [CNT_W-1:0]  t_lim;

  assign target  = stby_n ? sel_to_step(gsel) : '0;
  assign wake_ok = stby_n && !lat_q && !hot_flt;
  assign fault   = (short_flt || hot_flt) && (st_q != CH_OFF);

  always_comb begin
    st_d   = st_q;
    gain_d = gain_q;
    lat_d  = lat_q;
    if (!stby_n) lat_d = 1'b0;
    if (short_flt && (st_q != CH_OFF)) lat_d = 1'b1;
    case (st_q)
      CH_OFF:  if (wake_ok) st_d = CH_MUTE;
      CH_MUTE: begin
        if (!stby_n)   st_d = CH_OFF;
        else if (tick) st_d = CH_RUN;
      end
      CH_RUN: begin
        if (!stby_n) st_d = CH_DOWN;
        else if (tick && (gain_q != target))
          gain_d = (gain_q < target) ? gain_q + GAIN_W'(1) : gain_q - GAIN_W'(1);
      end
      CH_DOWN: begin
        if (gain_q == '0) st_d = CH_OFF;
        else if (tick)    gain_d = gain_q - GAIN_W'(1);
      end
      default: st_d = CH_OFF;
    endcase
    if (fault) begin
      st_d   = CH_OFF;
      gain_d = '0;
    end
  end

  assign t_clr = (st_d != st_q) || ((st_q == CH_RUN) && (gain_q == target));
  assign t_run = (st_q != CH_OFF);
  assign t_lim = (st_q == CH_MUTE) ? MUTE_LIM : DWELL_LIM;

  amp_dwell_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (t_clr),
    .run   (t_run),
    .limit (t_lim),
    .tick  (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_OFF;
      gain_q <= '0;
      lat_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      gain_q <= gain_d;
      lat_q  <= lat_d;
    end
  end

  assign gain_step = gain_q;
  assign out_en    = (st_q != CH_OFF);
  assign ch_active = (st_q == CH_RUN);

  // R12
  gain_slew_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != CH_OFF) |=> (st_q == CH_OFF) || (gain_q == $past(gain_q)) ||
                         (gain_q == $past(gain_q) + GAIN_W'(1)) ||
                         ($past(gain_q) == gain_q + GAIN_W'(1)));

  // R6
  hiz_at_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_OFF) |-> (gain_q == '0));

  // R2
  wake_from_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_OFF) |=> ((st_q == CH_OFF) || (st_q == CH_MUTE)) && (gain_q == '0));

  // R8
  short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q |-> (st_q == CH_OFF));

  // R9
  hot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot_flt |=> (st_q == CH_OFF));

endmodule

// File: rtl/amp_gain_seq_pair.sv
module amp_gain_seq_pair
  import amp_seq_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int MUTE_CYC  = 4000,
  parameter int DWELL_CYC = 2000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        stby_n,
  input  logic [NCH*SEL_W-1:0]  gsel,
  input  logic [NCH-1:0]        short_flt,
  input  logic                  hot_flt,
  output logic [NCH*GAIN_W-1:0] gain_step,
  output logic [NCH-1:0]        out_en,
  output logic [NCH-1:0]        ch_active,
  output logic                  all_off
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    amp_chan_seq #(
      .MUTE_CYC  (MUTE_CYC),
      .DWELL_CYC (DWELL_CYC)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .stby_n    (stby_n[c]),
      .gsel      (gsel[c*SEL_W +: SEL_W]),
      .short_flt (short_flt[c]),
      .hot_flt   (hot_flt),
      .gain_step (gain_step[c*GAIN_W +: GAIN_W]),
      .out_en    (out_en[c]),
      .ch_active (ch_active[c])
    );
  end

  assign all_off = ~|out_en;

  // R11
  active_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |ch_active |-> !all_off);

endmodule

// File: tb/sim_amp_gain_seq_pair.sv
module sim_amp_gain_seq_pair;

  localparam int NCH   = 2;
  localparam int MUTE  = 10;
  localparam int DWELL = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] stby_n;
  logic [2*NCH-1:0] gsel;
  logic [NCH-1:0] short_flt;
  logic           hot_flt;
  logic [3*NCH-1:0] gain_step;
  logic [NCH-1:0] out_en;
  logic [NCH-1:0] ch_active;
  logic           all_off;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  amp_gain_seq_pair #(.NCH(NCH), .MUTE_CYC(MUTE), .DWELL_CYC(DWELL)) u0 (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .gsel(gsel),
    .short_flt(short_flt), .hot_flt(hot_flt), .gain_step(gain_step),
    .out_en(out_en), .ch_active(ch_active), .all_off(all_off)
  );

  function automatic int gn(input int ch);
    return int'(gain_step[ch*3 +: 3]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 gain0", gn(0), 0);
    chk("R1 gain1", gn(1), 0);
    chk("R1 out_en", int'(out_en), 0);
    chk("R1 active", int'(ch_active), 0);
    chk("R1 all_off", int'(all_off), 1);
    step(3);
    chk("R2 off while standby", int'(out_en[0]), 0);
  endtask

  task automatic t_wake;
    gsel[1:0] = 2'b10;
    stby_n[0] = 1'b1;
    step(1);
    chk("R2 drive on", int'(out_en[0]), 1);
    chk("R2 mute at wake", gn(0), 0);
    step(MUTE - 1);
    chk("R11 inactive in mute", int'(ch_active[0]), 0);
    chk("R2 mute held", gn(0), 0);
    step(1);
    chk("R11 active after mute", int'(ch_active[0]), 1);
    step(DWELL - 1);
    chk("R4 before first step", gn(0), 0);
    step(1);
    chk("R4 first step", gn(0), 1);
    step(DWELL);
    chk("R4 second step", gn(0), 2);
    step(DWELL);
    chk("R4 third step", gn(0), 3);
    step(2 * DWELL);
    chk("R4 R3 holds preset 18dB", gn(0), 3);
  endtask

  task automatic t_change;
    gsel[1:0] = 2'b11;
    step(DWELL - 1);
    chk("R5 no jump", gn(0), 3);
    step(1);
    chk("R5 step up", gn(0), 4);
    gsel[1:0] = 2'b00;
    step(DWELL);
    chk("R5 down 1", gn(0), 3);
    step(DWELL);
    chk("R5 down 2", gn(0), 2);
    step(DWELL);
    chk("R5 down 3", gn(0), 1);
    step(2 * DWELL);
    chk("R5 holds", gn(0), 1);
  endtask

  task automatic t_decode;
    for (int s = 0; s < 4; s++) begin
      gsel[1:0] = 2'(s);
      step(4 * DWELL);
      chk("R3 decode", gn(0), s + 1);
    end
  endtask

  task automatic t_down;
    gsel[1:0] = 2'b01;
    step(3 * DWELL);
    chk("R5 settle 12dB", gn(0), 2);
    stby_n[0] = 1'b0;
    step(1);
    chk("R11 inactive in ramp down", int'(ch_active[0]), 0);
    chk("R6 drive kept", int'(out_en[0]), 1);
    step(DWELL - 1);
    chk("R6 hold", gn(0), 2);
    step(1);
    chk("R6 step down", gn(0), 1);
    step(DWELL);
    chk("R6 reach mute", gn(0), 0);
    chk("R6 drive at mute", int'(out_en[0]), 1);
    step(1);
    chk("R6 drive off", int'(out_en[0]), 0);
    chk("R10 all off", int'(all_off), 1);
  endtask

  task automatic t_reverse;
    gsel[1:0] = 2'b11;
    stby_n[0] = 1'b1;
    step(MUTE + 1 + 2 * DWELL);
    chk("R7 mid ramp", gn(0), 2);
    stby_n[0] = 1'b0;
    step(DWELL);
    chk("R7 no upward step", gn(0), 2);
    step(1);
    chk("R7 reversed", gn(0), 1);
    step(DWELL);
    chk("R7 mute", gn(0), 0);
    step(1);
    chk("R7 off", int'(out_en[0]), 0);
  endtask

  task automatic t_short;
    gsel[1:0] = 2'b00;
    stby_n[0] = 1'b1;
    step(MUTE + 1 + DWELL + 2);
    chk("R8 running", gn(0), 1);
    short_flt[0] = 1'b1;
    step(1);
    chk("R8 drive cut", int'(out_en[0]), 0);
    chk("R8 gain mute", gn(0), 0);
    short_flt[0] = 1'b0;
    step(3 * MUTE);
    chk("R8 latched off", int'(out_en[0]), 0);
    stby_n[0] = 1'b0;
    step(2);
    stby_n[0] = 1'b1;
    step(1);
    chk("R8 restart", int'(out_en[0]), 1);
    stby_n[0] = 1'b0;
    step(2);
    short_flt[0] = 1'b1;
    step(2);
    short_flt[0] = 1'b0;
    stby_n[0] = 1'b1;
    step(1);
    chk("R8 ignored while off", int'(out_en[0]), 1);
  endtask

  task automatic t_thermal;
    step(MUTE + 1 + DWELL + 2);
    gsel[3:2] = 2'b11;
    stby_n[1] = 1'b1;
    step(MUTE + 1 + 4 * DWELL + 2);
    chk("R10 ch1 gain", gn(1), 4);
    chk("R10 ch0 gain", gn(0), 1);
    chk("R10 not all off", int'(all_off), 0);
    hot_flt = 1'b1;
    step(1);
    chk("R9 both off", int'(out_en), 0);
    chk("R10 all off hot", int'(all_off), 1);
    step(5);
    chk("R9 stays off", int'(out_en), 0);
    hot_flt = 1'b0;
    step(1);
    chk("R9 auto wake", int'(out_en), 3);
    chk("R9 wake muted", gn(1), 0);
    step(MUTE + 1 + DWELL + 1);
    chk("R9 ramp again", gn(0), 1);
    stby_n[1] = 1'b0;
    step(5 * DWELL + 2);
    chk("R10 ch1 off", int'(out_en[1]), 0);
    chk("R10 ch0 on", int'(out_en[0]), 1);
    chk("R10 all_off low", int'(all_off), 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    stby_n    = '0;
    gsel      = '0;
    short_flt = '0;
    hot_flt   = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_wake();
    t_change();
    t_decode();
    t_down();
    t_reverse();
    t_short();
    t_thermal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule